// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Generator

This block turns a packet-transfer descriptor into the ordered stream of byte addresses that the packet touches. A packet is a set of patches, a patch is a set of lines, and a line is a run of adjacent bytes. The descriptor gives the first byte's address, the run length of a line, how many extra lines a patch has and how many extra patches the packet has, plus the signed distances between line starts and between patch starts.

Addresses leave on a valid/ready stream, one per accepted beat. Each descriptor also carries a link to the next descriptor and a stop flag. When a packet ends without the stop flag, the block raises a fetch request carrying the link address and waits for the next descriptor on its load port; with the stop flag it returns to idle. A one-cycle completion pulse marks the end of any packet whose descriptor asked for it.

Top module: `xfer_addr_gen`

## Requirements
- R1: After reset `addr_valid_o`, `fetch_req_o` and `done_o` are low and `load_ready_o` is high.
- R2: For indices a (byte), b (line), c (patch) the emitted address is start + c*patch_pitch + b*line_pitch + a modulo 2^32, with a varying fastest and c slowest.
- R3: `line_len_i` gives the bytes per line; a value of 0 emits one byte per line.
- R4: `lines_m1_i` is the number of lines per patch minus one and `patches_m1_i` the number of patches minus one; the packet emits exactly (lines_m1+1)*(patches_m1+1)*max(line_len,1) beats.
- R5: Both pitches are 32-bit two's-complement values, so negative pitches walk downward and addresses wrap modulo 2^32.
- R6: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `addr_valid_o` hold; the walk advances only on a beat with both high.
- R7: When the last beat of a packet is accepted and the descriptor's stop flag is 0, `fetch_req_o` rises on the next cycle with `fetch_addr_o` equal to the descriptor's link, and both hold until a new descriptor is loaded, which then starts a new packet.
- R8: When the last beat is accepted and the stop flag is 1, the block returns to idle: `fetch_req_o` and `addr_valid_o` stay low and `load_ready_o` is high.
- R9: `done_o` is high for exactly the one cycle after the last beat of a packet, and only if that descriptor's notify bit was 1.
- R10: `load_ready_o` is low while a packet is being walked, and a load presented then is ignored: the address stream of the running packet is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_valid_i | input | 1 | Descriptor present on load port |
| load_ready_o | output | 1 | Block can take a descriptor (not walking) |
| start_i | input | ADDR_W | Address of first byte of first line |
| line_len_i | input | CNT_W | Bytes per line (0 treated as 1) |
| lines_m1_i | input | CNT_W | Lines per patch minus one |
| patches_m1_i | input | CNT_W | Patches per packet minus one |
| line_pitch_i | input | ADDR_W | Signed distance between line starts |
| patch_pitch_i | input | ADDR_W | Signed distance between patch starts |
| link_i | input | ADDR_W | Address of the next descriptor |
| stop_i | input | 1 | Last descriptor in the list |
| notify_i | input | 1 | Request a completion pulse |
| addr_valid_o | output | 1 | Address beat valid |
| addr_ready_i | input | 1 | Consumer takes the beat |
| addr_o | output | ADDR_W | Byte address |
| fetch_req_o | output | 1 | Request for the next descriptor |
| fetch_addr_o | output | ADDR_W | Address of the requested descriptor |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults, 32-bit addresses and 16-bit counts, and drives small counts so every beat of each packet is compared against a nested-loop model. Full 32-bit pitches let a negative walk from a low start wrap below zero, and a zero line length reaches the single-byte case. Pseudo-random backpressure exercises holding under stall, and a two-entry list reaches the fetch wait state with a held request before the second load.

// File: rtl/xag_pkg.sv
package xag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2
  } xag_state_e;

  localparam int unsigned NUM_DIMS = 3;
  localparam int unsigned DIM_BYTE  = 0;
  localparam int unsigned DIM_LINE  = 1;
  localparam int unsigned DIM_PATCH = 2;
endpackage

// File: rtl/xag_dim_cnt.sv
module xag_dim_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             wrap_o
);
  assign wrap_o = (idx_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (clear_i) idx_o <= '0;
    else if (step_i)  idx_o <= wrap_o ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/xag_base.sv
module xag_base #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] line_pitch_i,
  input  logic [ADDR_W-1:0] patch_pitch_i,
  input  logic              next_line_i,
  input  logic              next_patch_i,
  output logic [ADDR_W-1:0] line_base_o
);
  logic [ADDR_W-1:0] line_pitch_q, patch_pitch_q, patch_base_q;
  logic [ADDR_W-1:0] patch_next;

  assign patch_next = patch_base_q + patch_pitch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_pitch_q  <= '0;
      patch_pitch_q <= '0;
      patch_base_q  <= '0;
      line_base_o   <= '0;
    end else if (load_i) begin
      line_pitch_q  <= line_pitch_i;
      patch_pitch_q <= patch_pitch_i;
      patch_base_q  <= start_i;
      line_base_o   <= start_i;
    end else if (next_patch_i) begin
      patch_base_q <= patch_next;
      line_base_o  <= patch_next;
    end else if (next_line_i) begin
      line_base_o <= line_base_o + line_pitch_q;
    end
  end
endmodule

// File: rtl/xag_fsm.sv
module xag_fsm
  import xag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  input  logic [ADDR_W-1:0] link_i,
  input  logic              stop_i,
  input  logic              notify_i,
  input  logic              pkt_end_i,
  output logic              load_fire_o,
  output logic              load_ready_o,
  output logic              running_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              done_o
);
  xag_state_e state_q;
  logic stop_q, notify_q;

  assign load_ready_o = (state_q != ST_RUN);
  assign load_fire_o  = load_valid_i & load_ready_o;
  assign running_o    = (state_q == ST_RUN);
  assign fetch_req_o  = (state_q == ST_FETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      stop_q       <= 1'b1;
      notify_q     <= 1'b0;
      fetch_addr_o <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= running_o & pkt_end_i & notify_q;
      if (load_fire_o) begin
        state_q      <= ST_RUN;
        stop_q       <= stop_i;
        notify_q     <= notify_i;
        fetch_addr_o <= link_i;
      end else if (running_o && pkt_end_i) begin
        state_q <= stop_q ? ST_IDLE : ST_FETCH;
      end
    end
  end
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
  import xag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  output logic              load_ready_o,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [CNT_W-1:0]  line_len_i,
  input  logic [CNT_W-1:0]  lines_m1_i,
  input  logic [CNT_W-1:0]  patches_m1_i,
  input  logic [ADDR_W-1:0] line_pitch_i,
  input  logic [ADDR_W-1:0] patch_pitch_i,
  input  logic [ADDR_W-1:0] link_i,
  input  logic              stop_i,
  input  logic              notify_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              done_o
);
  localparam int unsigned PAD_W = ADDR_W - CNT_W;

  logic                     load_fire, running, beat, pkt_end;
  logic [NUM_DIMS-1:0]      step, wrap;
  logic [CNT_W-1:0]         last_d [NUM_DIMS];
  logic [CNT_W-1:0]         last_q [NUM_DIMS];
  logic [CNT_W-1:0]         idx    [NUM_DIMS];
  logic [ADDR_W-1:0]        line_base;

  // zero line length behaves as a one-byte line
  assign last_d[DIM_BYTE]  = (line_len_i == '0) ? '0 : line_len_i - 1'b1;
  assign last_d[DIM_LINE]  = lines_m1_i;
  assign last_d[DIM_PATCH] = patches_m1_i;

  assign addr_valid_o = running;
  assign beat         = running & addr_ready_i;
  assign step[DIM_BYTE] = beat;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    if (d > 0) begin : g_carry
      assign step[d] = step[d-1] & wrap[d-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        last_q[d] <= '0;
      else if (load_fire) last_q[d] <= last_d[d];
    end
    xag_dim_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (load_fire),
      .step_i  (step[d]),
      .last_i  (last_q[d]),
      .idx_o   (idx[d]),
      .wrap_o  (wrap[d])
    );
  end

  assign pkt_end = step[DIM_PATCH] & wrap[DIM_PATCH];

  xag_base #(.ADDR_W(ADDR_W)) u_base (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load_fire),
    .start_i       (start_i),
    .line_pitch_i  (line_pitch_i),
    .patch_pitch_i (patch_pitch_i),
    .next_line_i   (step[DIM_LINE]),
    .next_patch_i  (step[DIM_PATCH]),
    .line_base_o   (line_base)
  );

  assign addr_o = line_base + {{PAD_W{1'b0}}, idx[DIM_BYTE]};

  xag_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_valid_i (load_valid_i),
    .link_i       (link_i),
    .stop_i       (stop_i),
    .notify_i     (notify_i),
    .pkt_end_i    (pkt_end),
    .load_fire_o  (load_fire),
    .load_ready_o (load_ready_o),
    .running_o    (running),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/xag_chk.sv
module xag_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_valid_i,
  input logic              load_ready_o,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              done_o
);
  // R6: stalled beat holds
  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o));

  // R10: no load accepted mid-walk
  p_busy_no_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_valid_o && load_ready_o));

  // R9: single-cycle pulse, only after an accepted beat
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(addr_valid_o && addr_ready_i));

  // R7: fetch request and its address hold until a load
  p_fetch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !load_valid_i |=> fetch_req_o && $stable(fetch_addr_o));

  // R8: fetch and walk never overlap
  p_fetch_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> !addr_valid_o);
endmodule

bind xfer_addr_gen xag_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_valid_i (load_valid_i),
  .load_ready_o (load_ready_o),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .addr_o       (addr_o),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o),
  .done_o       (done_o)
);

// File: tb/sim_xfer_addr_gen.sv
`timescale 1ns/1ps
module sim_xfer_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_valid_i = 1'b0;
  logic        load_ready_o;
  logic [31:0] start_i = '0;
  logic [15:0] line_len_i = '0, lines_m1_i = '0, patches_m1_i = '0;
  logic [31:0] line_pitch_i = '0, patch_pitch_i = '0, link_i = '0;
  logic        stop_i = 1'b0, notify_i = 1'b0;
  logic        addr_valid_o;
  logic        addr_ready_i = 1'b0;
  logic [31:0] addr_o;
  logic        fetch_req_o;
  logic [31:0] fetch_addr_o;
  logic        done_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] lf = 8'h5a;

  always #2 clk_i = ~clk_i;

  xfer_addr_gen u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] st, input logic [15:0] ac, bc, cc,
                         input logic [31:0] bp, cp, lk, input bit stp, input bit ntf);
    @(negedge clk_i);
    chk(load_ready_o == 1'b1, "R7 load_ready before load", {31'b0, load_ready_o}, 32'd1);
    start_i = st; line_len_i = ac; lines_m1_i = bc; patches_m1_i = cc;
    line_pitch_i = bp; patch_pitch_i = cp; link_i = lk; stop_i = stp; notify_i = ntf;
    load_valid_i = 1'b1;
    @(negedge clk_i);
    load_valid_i = 1'b0;
  endtask

  // walks the expected sequence; stall adds backpressure, junk presents a load mid-walk
  task automatic walk(input logic [31:0] st, input logic [15:0] ac, bc, cc,
                      input logic [31:0] bp, cp, input bit stall, input bit junk, input string req);
    int ae;
    logic [31:0] held;
    bit was_held;
    ae = (ac == 0) ? 1 : int'(ac);
    was_held = 1'b0;
    held = '0;
    for (int c = 0; c <= int'(cc); c++)
      for (int b = 0; b <= int'(bc); b++)
        for (int a = 0; a < ae; a++) begin
          logic [31:0] exp;
          exp = st + 32'(c) * cp + 32'(b) * bp + 32'(a);
          do begin
            @(negedge clk_i);
            if (junk) begin
              load_valid_i = 1'b1; start_i = 32'hdead_0000; line_len_i = 16'd9;
              line_pitch_i = 32'h7; patch_pitch_i = 32'h9;
            end
            if (was_held) begin
              chk(addr_valid_o && addr_o == held, "R6 hold under stall", addr_o, held);
              was_held = 1'b0;
            end
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            addr_ready_i = stall ? lf[0] : 1'b1;
            if (addr_valid_o && !addr_ready_i) begin
              held = addr_o; was_held = 1'b1;
            end
          end while (!(addr_valid_o && addr_ready_i));
          chk(addr_o == exp, req, addr_o, exp);
        end
  endtask

  task automatic after_pkt(input bit ntf, input bit stp, input logic [31:0] lk);
    @(negedge clk_i);
    addr_ready_i = 1'b0;
    load_valid_i = 1'b0;
    chk(done_o == ntf, "R9 done after last beat", {31'b0, done_o}, {31'b0, ntf});
    chk(addr_valid_o == 1'b0, "R4 no extra beat", {31'b0, addr_valid_o}, 32'd0);
    if (stp) begin
      chk(fetch_req_o == 1'b0 && load_ready_o, "R8 idle after stop", {31'b0, fetch_req_o}, 32'd0);
    end else begin
      chk(fetch_req_o == 1'b1, "R7 fetch request", {31'b0, fetch_req_o}, 32'd1);
      chk(fetch_addr_o == lk, "R7 fetch address", fetch_addr_o, lk);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 single cycle done", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(!addr_valid_o && !fetch_req_o && !done_o && load_ready_o, "R1 reset state",
        {28'b0, addr_valid_o, fetch_req_o, done_o, load_ready_o}, 32'h1);
  endtask

  task automatic t_basic();
    do_load(32'h0000_1000, 16'd4, 16'd2, 16'd1, 32'h100, 32'h1000, 32'h0, 1'b1, 1'b1);
    walk(32'h0000_1000, 16'd4, 16'd2, 16'd1, 32'h100, 32'h1000, 1'b0, 1'b0, "R2 R4 basic order");
    after_pkt(1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_negative();
    do_load(32'h0000_0020, 16'd3, 16'd1, 16'd2, 32'hffff_fff0, 32'hffff_ffc0, 32'h0, 1'b1, 1'b0);
    walk(32'h0000_0020, 16'd3, 16'd1, 16'd2, 32'hffff_fff0, 32'hffff_ffc0, 1'b1, 1'b0, "R5 R6 negative pitch");
    after_pkt(1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_zero_len();
    do_load(32'h0000_8000, 16'd0, 16'd1, 16'd1, 32'h10, 32'h100, 32'h0, 1'b1, 1'b1);
    walk(32'h0000_8000, 16'd0, 16'd1, 16'd1, 32'h10, 32'h100, 1'b0, 1'b0, "R3 zero line length");
    after_pkt(1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_list();
    do_load(32'h0001_0000, 16'd2, 16'd1, 16'd0, 32'h40, 32'h0, 32'h0000_abc0, 1'b0, 1'b1);
    walk(32'h0001_0000, 16'd2, 16'd1, 16'd0, 32'h40, 32'h0, 1'b0, 1'b0, "R2 list entry one");
    after_pkt(1'b1, 1'b0, 32'h0000_abc0);
    repeat (3) @(negedge clk_i);
    chk(fetch_req_o && fetch_addr_o == 32'h0000_abc0, "R7 fetch held", fetch_addr_o, 32'h0000_abc0);
    do_load(32'h0002_0000, 16'd1, 16'd0, 16'd2, 32'h0, 32'h8, 32'h0, 1'b1, 1'b0);
    chk(!fetch_req_o, "R7 fetch drops on load", {31'b0, fetch_req_o}, 32'd0);
    walk(32'h0002_0000, 16'd1, 16'd0, 16'd2, 32'h0, 32'h8, 1'b1, 1'b0, "R7 list entry two");
    after_pkt(1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_busy_load();
    do_load(32'h0003_0000, 16'd3, 16'd1, 16'd1, 32'h20, 32'h200, 32'h0, 1'b1, 1'b0);
    chk(!load_ready_o, "R10 busy not ready", {31'b0, load_ready_o}, 32'd0);
    walk(32'h0003_0000, 16'd3, 16'd1, 16'd1, 32'h20, 32'h200, 1'b1, 1'b1, "R10 load ignored while busy");
    after_pkt(1'b0, 1'b1, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_negative();
    t_zero_len();
    t_list();
    t_busy_load();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule